// File: doc/BRIEF.md
# Spare Device Sparing Controller

This block manages device sparing for memory ranks built from x4 DRAM devices. In each rank one device is held back as a spare and carries no normal data. When a hard failure of a data device is reported for a rank, the controller migrates that device's contents into the spare. It walks every line of the rank and issues a read to the scheduler. It takes the corrected line from the external ECC decoder and writes the failed device's nibble back as a spare-device write. It then records a remap of the failed device to the spare for that rank.

A second failure reported on a rank that has already been remapped is not migrated. The controller latches the rank and device number in sticky status and pulses a request to the regular device recovery path. While sparing is in effect, the external ECC runs in a 16-bit nibble-parity mode. It does not use the 32-bit byte-parity mode. Multi-error words that exceed device correction are then reported as uncorrectable.

Failure reports enter through a valid/ready port with a one-entry holding register. Reads, read responses and spare writes are valid/ready channels. A request, once valid, keeps its fields stable until ready is seen high at a clock edge. The controller accepts read data only while it is waiting for it. Configuration pins are static while a migration runs.

Top module: `sds_top`

## Requirements
- R1: After reset, `busy`, `rd_req_valid`, `wr_req_valid`, `recovery_req`, `second_seen` and every `remap_valid` bit are 0, and `fail_ready` is 1.
- R2: `sparing_active` and `ecc_nibble_mode` are 1 exactly when `cfg_sparing_en` is 1, `cfg_all_x4` is 1 and `cfg_mirror_master` is 0.
- R3: `ecc_uncorr` equals `ecc_multi_err` while sparing is active, and `ecc_fixable` equals `ecc_multi_err` while it is not. The two are never high together.
- R4: A report is taken on a clock edge where `fail_valid` and `fail_ready` are both high. `fail_ready` is low while the one-entry holding register is occupied.
- R5: A migration for rank r and device d visits lines 0 to `cfg_rank_lines`-1 in increasing order. For each line it issues one read (r, line) and waits for a response. It then issues one write (r, line) whose nibble is bits [4d+3:4d] of the response. The next read starts only after that write is accepted, and reads and writes are never valid together.
- R6: A read or write request that is valid and not accepted stays valid with unchanged rank and line in the next cycle.
- R7: When a migration ends, `remap_valid[r]` goes high with `remap_dev` field r (bits [5r+4:5r]) equal to d in the same cycle that `busy` falls.
- R8: With `cfg_rank_lines` equal to 0, a first failure remaps the rank without any read or write.
- R9: A report is consumed and dropped, with no traffic and no remap, when sparing is inactive or the device index is not a data device (index at least `NUM_DEV`-1, the spare being index `NUM_DEV`-1).
- R10: A report on a rank whose remap is valid causes no traffic. It sets `second_seen` and loads `second_rank`/`second_dev` with the report. It also raises `recovery_req` for exactly one cycle.
- R11: A report arriving while a migration runs is held and processed after it. Further reports are refused until the held one is taken.
- R12: Once set, a rank's remap valid bit and device index do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sparing_en | input | 1 | Sparing enable request |
| cfg_all_x4 | input | 1 | Every populated rank uses x4 devices |
| cfg_mirror_master | input | 1 | Controller is a mirroring master |
| cfg_rank_lines | input | LINE_W+1 | Number of lines per rank to migrate |
| sparing_active | output | 1 | Sparing is in effect |
| ecc_nibble_mode | output | 1 | Selects 16-bit nibble-parity ECC mode |
| ecc_multi_err | input | 1 | ECC saw errors beyond device correction |
| ecc_uncorr | output | 1 | Multi-error flagged uncorrectable |
| ecc_fixable | output | 1 | Multi-error left to normal correction |
| fail_valid | input | 1 | Failure report valid |
| fail_ready | output | 1 | Failure report can be taken |
| fail_rank | input | RANK_W | Rank of the failed device |
| fail_dev | input | 5 | Index of the failed device |
| busy | output | 1 | Controller is not idle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_rank | output | RANK_W | Read rank |
| rd_req_line | output | LINE_W | Read line |
| rd_rsp_valid | input | 1 | Corrected read data valid |
| rd_rsp_ready | output | 1 | Controller takes read data |
| rd_rsp_data | input | NUM_DEV*4 | Corrected line, device k at bits [4k+3:4k] |
| wr_req_valid | output | 1 | Spare write valid |
| wr_req_ready | input | 1 | Spare write accepted |
| wr_req_rank | output | RANK_W | Write rank |
| wr_req_line | output | LINE_W | Write line |
| wr_req_nibble | output | 4 | Nibble for the spare device |
| remap_valid | output | NUM_RANKS | Per-rank remap in effect |
| remap_dev | output | NUM_RANKS*5 | Per-rank remapped device index |
| recovery_req | output | 1 | One-cycle request to regular recovery |
| second_seen | output | 1 | A second failure has been recorded |
| second_rank | output | RANK_W | Rank of the last second failure |
| second_dev | output | 5 | Device of the last second failure |

## Verification
The hardest case to reach is a report that lands while a migration is under way and the holding register is already full. That is the only time `fail_ready` is low with a valid report pending, and the one ordering the holding logic must get right. The bench starts a migration over several lines with random back-pressure on every channel. It posts a second report, which the controller takes into the holding register at once. A third report then waits at the port until the migration ends. The reference model expects the three migrations to follow back to back in report order.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int DEV_IDX_W = 5;
  localparam int NIB_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY_RD,
    ST_COPY_WAIT,
    ST_COPY_WR,
    ST_REMAP_DONE,
    ST_SECOND_FAIL
  } sds_state_e;
endpackage

// File: rtl/sds_pend_buf.sv
module sds_pend_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_pop) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sds_remap_tbl.sv
module sds_remap_tbl #(
  parameter int NUM_RANKS = 8,
  parameter int RANK_W    = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      set_en,
  input  logic [RANK_W-1:0]                         set_rank,
  input  logic [sds_pkg::DEV_IDX_W-1:0]             set_dev,
  output logic [NUM_RANKS-1:0]                      valid_o,
  output logic [NUM_RANKS*sds_pkg::DEV_IDX_W-1:0]   dev_o
);
  localparam int DW = sds_pkg::DEV_IDX_W;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic          v_q;
    logic [DW-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (set_en && (set_rank == RANK_W'(r)) && !v_q) begin
        v_q <= 1'b1;
        d_q <= set_dev;
      end
    end

    assign valid_o[r]          = v_q;
    assign dev_o[r*DW +: DW]   = d_q;
  end
endmodule

// File: rtl/sds_copy_seq.sv
module sds_copy_seq
  import sds_pkg::*;
#(
  parameter int NUM_RANKS = 8,
  parameter int NUM_DEV   = 18,
  parameter int LINE_W    = 6,
  parameter int RANK_W    = 3,
  parameter int DATA_W    = 72
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_i,
  input  logic [LINE_W:0]       rank_lines_i,
  input  logic                  pend_valid_i,
  input  logic [RANK_W-1:0]     pend_rank_i,
  input  logic [DEV_IDX_W-1:0]  pend_dev_i,
  output logic                  pend_pop_o,
  input  logic [NUM_RANKS-1:0]  spared_i,
  output logic                  busy_o,
  output logic                  rd_req_valid_o,
  input  logic                  rd_req_ready_i,
  output logic [RANK_W-1:0]     rd_req_rank_o,
  output logic [LINE_W-1:0]     rd_req_line_o,
  input  logic                  rd_rsp_valid_i,
  output logic                  rd_rsp_ready_o,
  input  logic [DATA_W-1:0]     rd_rsp_data_i,
  output logic                  wr_req_valid_o,
  input  logic                  wr_req_ready_i,
  output logic [RANK_W-1:0]     wr_req_rank_o,
  output logic [LINE_W-1:0]     wr_req_line_o,
  output logic [NIB_W-1:0]      wr_req_nibble_o,
  output logic                  remap_set_o,
  output logic [RANK_W-1:0]     remap_rank_o,
  output logic [DEV_IDX_W-1:0]  remap_dev_o,
  output logic                  recovery_req_o,
  output logic                  second_seen_o,
  output logic [RANK_W-1:0]     second_rank_o,
  output logic [DEV_IDX_W-1:0]  second_dev_o
);
  localparam int SPARE_IDX = NUM_DEV - 1;
  localparam int SEL_W     = DEV_IDX_W + 2;

  sds_state_e           state_q;
  logic [RANK_W-1:0]    rank_q;
  logic [DEV_IDX_W-1:0] dev_q;
  logic [LINE_W-1:0]    line_q;
  logic [LINE_W:0]      lines_q;
  logic [NIB_W-1:0]     nib_q;
  logic                 sec_seen_q;
  logic [RANK_W-1:0]    sec_rank_q;
  logic [DEV_IDX_W-1:0] sec_dev_q;

  logic            dev_ok, rank_ok, rank_spared, take_ok, last_line;
  logic [SEL_W-1:0] nib_sel;

  assign dev_ok      = pend_dev_i < DEV_IDX_W'(SPARE_IDX);
  assign rank_ok     = {1'b0, pend_rank_i} < (RANK_W+1)'(NUM_RANKS);
  assign rank_spared = rank_ok && spared_i[pend_rank_i];
  assign take_ok     = active_i && dev_ok && rank_ok;
  assign last_line   = ({1'b0, line_q} + (LINE_W+1)'(1)) == lines_q;
  assign nib_sel     = {dev_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rank_q     <= '0;
      dev_q      <= '0;
      line_q     <= '0;
      lines_q    <= '0;
      nib_q      <= '0;
      sec_seen_q <= 1'b0;
      sec_rank_q <= '0;
      sec_dev_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pend_valid_i && take_ok) begin
            rank_q  <= pend_rank_i;
            dev_q   <= pend_dev_i;
            line_q  <= '0;
            lines_q <= rank_lines_i;
            if (rank_spared) begin
              sec_seen_q <= 1'b1;
              sec_rank_q <= pend_rank_i;
              sec_dev_q  <= pend_dev_i;
              state_q    <= ST_SECOND_FAIL;
            end else if (rank_lines_i == '0) begin
              state_q <= ST_REMAP_DONE;
            end else begin
              state_q <= ST_COPY_RD;
            end
          end
        end
        ST_COPY_RD: begin
          if (rd_req_ready_i) state_q <= ST_COPY_WAIT;
        end
        ST_COPY_WAIT: begin
          if (rd_rsp_valid_i) begin
            nib_q   <= rd_rsp_data_i[nib_sel +: NIB_W];
            state_q <= ST_COPY_WR;
          end
        end
        ST_COPY_WR: begin
          if (wr_req_ready_i) begin
            if (last_line) begin
              state_q <= ST_REMAP_DONE;
            end else begin
              line_q  <= line_q + LINE_W'(1);
              state_q <= ST_COPY_RD;
            end
          end
        end
        ST_REMAP_DONE:  state_q <= ST_IDLE;
        ST_SECOND_FAIL: state_q <= ST_IDLE;
        default:        state_q <= ST_IDLE;
      endcase
    end
  end

  assign pend_pop_o      = (state_q == ST_IDLE) && pend_valid_i;
  assign busy_o          = (state_q != ST_IDLE);
  assign rd_req_valid_o  = (state_q == ST_COPY_RD);
  assign rd_req_rank_o   = rank_q;
  assign rd_req_line_o   = line_q;
  assign rd_rsp_ready_o  = (state_q == ST_COPY_WAIT);
  assign wr_req_valid_o  = (state_q == ST_COPY_WR);
  assign wr_req_rank_o   = rank_q;
  assign wr_req_line_o   = line_q;
  assign wr_req_nibble_o = nib_q;
  assign remap_set_o     = (state_q == ST_REMAP_DONE);
  assign remap_rank_o    = rank_q;
  assign remap_dev_o     = dev_q;
  assign recovery_req_o  = (state_q == ST_SECOND_FAIL);
  assign second_seen_o   = sec_seen_q;
  assign second_rank_o   = sec_rank_q;
  assign second_dev_o    = sec_dev_q;
endmodule

// File: rtl/sds_top.sv
module sds_top #(
  parameter int NUM_RANKS = 8,
  parameter int NUM_DEV   = 18,
  parameter int LINE_W    = 6,
  parameter int RANK_W    = $clog2(NUM_RANKS),
  parameter int DATA_W    = NUM_DEV * sds_pkg::NIB_W
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cfg_sparing_en,
  input  logic                                    cfg_all_x4,
  input  logic                                    cfg_mirror_master,
  input  logic [LINE_W:0]                         cfg_rank_lines,
  output logic                                    sparing_active,
  output logic                                    ecc_nibble_mode,
  input  logic                                    ecc_multi_err,
  output logic                                    ecc_uncorr,
  output logic                                    ecc_fixable,
  input  logic                                    fail_valid,
  output logic                                    fail_ready,
  input  logic [RANK_W-1:0]                       fail_rank,
  input  logic [sds_pkg::DEV_IDX_W-1:0]           fail_dev,
  output logic                                    busy,
  output logic                                    rd_req_valid,
  input  logic                                    rd_req_ready,
  output logic [RANK_W-1:0]                       rd_req_rank,
  output logic [LINE_W-1:0]                       rd_req_line,
  input  logic                                    rd_rsp_valid,
  output logic                                    rd_rsp_ready,
  input  logic [DATA_W-1:0]                       rd_rsp_data,
  output logic                                    wr_req_valid,
  input  logic                                    wr_req_ready,
  output logic [RANK_W-1:0]                       wr_req_rank,
  output logic [LINE_W-1:0]                       wr_req_line,
  output logic [sds_pkg::NIB_W-1:0]               wr_req_nibble,
  output logic [NUM_RANKS-1:0]                    remap_valid,
  output logic [NUM_RANKS*sds_pkg::DEV_IDX_W-1:0] remap_dev,
  output logic                                    recovery_req,
  output logic                                    second_seen,
  output logic [RANK_W-1:0]                       second_rank,
  output logic [sds_pkg::DEV_IDX_W-1:0]           second_dev
);
  localparam int DW  = sds_pkg::DEV_IDX_W;
  localparam int RPW = RANK_W + DW;

  logic            active;
  logic            pend_valid, pend_pop;
  logic [RPW-1:0]  pend_data;
  logic            remap_set;
  logic [RANK_W-1:0] remap_set_rank;
  logic [DW-1:0]   remap_set_dev;

  assign active          = cfg_sparing_en && cfg_all_x4 && !cfg_mirror_master;
  assign sparing_active  = active;
  assign ecc_nibble_mode = active;
  assign ecc_uncorr      = ecc_multi_err && active;
  assign ecc_fixable     = ecc_multi_err && !active;

  sds_pend_buf #(.W(RPW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (fail_valid),
    .in_ready (fail_ready),
    .in_data  ({fail_rank, fail_dev}),
    .out_valid(pend_valid),
    .out_pop  (pend_pop),
    .out_data (pend_data)
  );

  sds_copy_seq #(
    .NUM_RANKS(NUM_RANKS), .NUM_DEV(NUM_DEV), .LINE_W(LINE_W),
    .RANK_W(RANK_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .active_i       (active),
    .rank_lines_i   (cfg_rank_lines),
    .pend_valid_i   (pend_valid),
    .pend_rank_i    (pend_data[RPW-1:DW]),
    .pend_dev_i     (pend_data[DW-1:0]),
    .pend_pop_o     (pend_pop),
    .spared_i       (remap_valid),
    .busy_o         (busy),
    .rd_req_valid_o (rd_req_valid),
    .rd_req_ready_i (rd_req_ready),
    .rd_req_rank_o  (rd_req_rank),
    .rd_req_line_o  (rd_req_line),
    .rd_rsp_valid_i (rd_rsp_valid),
    .rd_rsp_ready_o (rd_rsp_ready),
    .rd_rsp_data_i  (rd_rsp_data),
    .wr_req_valid_o (wr_req_valid),
    .wr_req_ready_i (wr_req_ready),
    .wr_req_rank_o  (wr_req_rank),
    .wr_req_line_o  (wr_req_line),
    .wr_req_nibble_o(wr_req_nibble),
    .remap_set_o    (remap_set),
    .remap_rank_o   (remap_set_rank),
    .remap_dev_o    (remap_set_dev),
    .recovery_req_o (recovery_req),
    .second_seen_o  (second_seen),
    .second_rank_o  (second_rank),
    .second_dev_o   (second_dev)
  );

  sds_remap_tbl #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_remap (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (remap_set),
    .set_rank(remap_set_rank),
    .set_dev (remap_set_dev),
    .valid_o (remap_valid),
    .dev_o   (remap_dev)
  );
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int NUM_RANKS = 8,
  parameter int LINE_W    = 6,
  parameter int RANK_W    = 3
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic [LINE_W:0]                         cfg_rank_lines,
  input logic                                    ecc_uncorr,
  input logic                                    ecc_fixable,
  input logic                                    busy,
  input logic                                    rd_req_valid,
  input logic                                    rd_req_ready,
  input logic [RANK_W-1:0]                       rd_req_rank,
  input logic [LINE_W-1:0]                       rd_req_line,
  input logic                                    wr_req_valid,
  input logic                                    wr_req_ready,
  input logic [RANK_W-1:0]                       wr_req_rank,
  input logic [LINE_W-1:0]                       wr_req_line,
  input logic [NUM_RANKS-1:0]                    remap_valid,
  input logic [NUM_RANKS*sds_pkg::DEV_IDX_W-1:0] remap_dev,
  input logic                                    recovery_req,
  input logic                                    second_seen
);
  localparam int DW = sds_pkg::DEV_IDX_W;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_rank) && $stable(rd_req_line))); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_rank) && $stable(wr_req_line))); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_req_valid)); // R5
  AST_TRAFFIC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_req_valid) |-> busy); // R5
  AST_WR_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> ({1'b0, wr_req_line} < cfg_rank_lines)); // R5
  AST_ECC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ecc_uncorr && ecc_fixable)); // R3
  AST_RECOV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_req |=> !recovery_req); // R10
  AST_RECOV_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_req |-> second_seen); // R10

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_sticky
    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      remap_valid[r] |=> (remap_valid[r] && $stable(remap_dev[r*DW +: DW]))); // R12
  end
endmodule

bind sds_top sds_checker #(
  .NUM_RANKS(NUM_RANKS), .LINE_W(LINE_W), .RANK_W(RANK_W)
) u_sds_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rank_lines(cfg_rank_lines),
  .ecc_uncorr    (ecc_uncorr),
  .ecc_fixable   (ecc_fixable),
  .busy          (busy),
  .rd_req_valid  (rd_req_valid),
  .rd_req_ready  (rd_req_ready),
  .rd_req_rank   (rd_req_rank),
  .rd_req_line   (rd_req_line),
  .wr_req_valid  (wr_req_valid),
  .wr_req_ready  (wr_req_ready),
  .wr_req_rank   (wr_req_rank),
  .wr_req_line   (wr_req_line),
  .remap_valid   (remap_valid),
  .remap_dev     (remap_dev),
  .recovery_req  (recovery_req),
  .second_seen   (second_seen)
);

// File: tb/test_sds_top.sv
module test_sds_top;
  localparam int NR = 8;
  localparam int ND = 18;
  localparam int LW = 6;
  localparam int RW = 3;
  localparam int DW = ND * 4;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic          cfg_sparing_en = 0, cfg_all_x4 = 0, cfg_mirror_master = 0;
  logic [LW:0]   cfg_rank_lines = '0;
  logic          sparing_active, ecc_nibble_mode, ecc_multi_err = 0, ecc_uncorr, ecc_fixable;
  logic          fail_valid = 0, fail_ready;
  logic [RW-1:0] fail_rank = '0;
  logic [4:0]    fail_dev = '0;
  logic          busy;
  logic          rd_req_valid, rd_req_ready = 0;
  logic [RW-1:0] rd_req_rank;
  logic [LW-1:0] rd_req_line;
  logic          rd_rsp_valid = 0, rd_rsp_ready;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          wr_req_valid, wr_req_ready = 0;
  logic [RW-1:0] wr_req_rank;
  logic [LW-1:0] wr_req_line;
  logic [3:0]    wr_req_nibble;
  logic [NR-1:0] remap_valid;
  logic [NR*5-1:0] remap_dev;
  logic          recovery_req, second_seen;
  logic [RW-1:0] second_rank;
  logic [4:0]    second_dev;

  sds_top #(.NUM_RANKS(NR), .NUM_DEV(ND), .LINE_W(LW)) i_sds_top (.*);

  int checks = 0, failures = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, rec_cnt = 0;

  typedef struct { int rank; int dev; int lines; } copy_t;
  copy_t exp_q[$];
  int cur_line = 0;
  bit rd_done = 0;
  int rsp_q[$];
  int rsp_delay = 0;
  bit rd_hold = 0, wr_hold = 0;
  int rd_hold_rank, rd_hold_line, wr_hold_rank, wr_hold_line;
  logic [NR-1:0] prev_remap;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(int rank, int line, int dev);
    return 4'((line * 11 + rank * 5 + dev * 7 + (line >> 2) * 3 + dev * line) & 15);
  endfunction

  function automatic logic [DW-1:0] word_of(int rank, int line);
    logic [DW-1:0] w;
    for (int d = 0; d < ND; d++) w[d*4 +: 4] = nib_of(rank, line, d);
    return w;
  endfunction

  // behavioural memory, back-pressure and reference model, evaluated each cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (recovery_req) rec_cnt++;
      if (rd_hold)
        chk(rd_req_valid && int'(rd_req_rank) == rd_hold_rank && int'(rd_req_line) == rd_hold_line,
            "R6 read hold", int'(rd_req_line), rd_hold_line);
      if (wr_hold)
        chk(wr_req_valid && int'(wr_req_rank) == wr_hold_rank && int'(wr_req_line) == wr_hold_line,
            "R6 write hold", int'(wr_req_line), wr_hold_line);
      rd_req_ready = ($urandom % 4) != 0;
      wr_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        rd_cnt++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected read", int'(rd_req_line), -1);
        else begin
          chk(int'(rd_req_rank) == exp_q[0].rank && int'(rd_req_line) == cur_line && !rd_done,
              "R5 read order", int'(rd_req_line), cur_line);
          rd_done = 1;
        end
        rsp_q.push_back(int'(rd_req_rank) * 256 + int'(rd_req_line));
        rsp_delay = $urandom % 3;
      end
      rd_hold = rd_req_valid && !rd_req_ready;
      rd_hold_rank = int'(rd_req_rank);
      rd_hold_line = int'(rd_req_line);
      if (wr_req_valid && wr_req_ready) begin
        wr_cnt++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected write", int'(wr_req_line), -1);
        else begin
          chk(int'(wr_req_rank) == exp_q[0].rank && int'(wr_req_line) == cur_line && rd_done,
              "R5 write order", int'(wr_req_line), cur_line);
          chk(wr_req_nibble == nib_of(exp_q[0].rank, cur_line, exp_q[0].dev),
              "R5 spare nibble", wr_req_nibble, nib_of(exp_q[0].rank, cur_line, exp_q[0].dev));
          rd_done = 0;
          cur_line++;
          if (cur_line == exp_q[0].lines) begin
            void'(exp_q.pop_front());
            cur_line = 0;
          end
        end
      end
      wr_hold = wr_req_valid && !wr_req_ready;
      wr_hold_rank = int'(wr_req_rank);
      wr_hold_line = int'(wr_req_line);
      rd_rsp_valid = 0;
      if (rsp_q.size() != 0) begin
        if (rsp_delay > 0) rsp_delay--;
        else begin
          rd_rsp_valid = 1;
          rd_rsp_data = word_of(rsp_q[0] / 256, rsp_q[0] % 256);
          if (rd_rsp_ready) void'(rsp_q.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input int rank, input int dev);
    fail_rank = RW'(rank);
    fail_dev = 5'(dev);
    fail_valid = 1;
    while (!fail_ready) @(negedge clk);
    @(negedge clk);
    fail_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    prev_remap = remap_valid;
    while (!(fail_ready && !busy)) begin
      prev_remap = remap_valid;
      @(negedge clk);
      n++;
      if (n > 20000) begin
        chk(0, "idle timeout", n, 0);
        break;
      end
    end
  endtask

  function automatic int dev_at(int r);
    return int'(remap_dev[r*5 +: 5]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && fail_ready, "R1 idle/ready", busy, 0);
    chk(!rd_req_valid && !wr_req_valid, "R1 no requests", rd_req_valid, 0);
    chk(remap_valid == '0 && !second_seen && !recovery_req, "R1 status clear", remap_valid, 0);

    // R2 and R3 over every configuration
    for (int c = 0; c < 8; c++) begin
      cfg_sparing_en = c[0];
      cfg_all_x4 = c[1];
      cfg_mirror_master = c[2];
      for (int m = 0; m < 2; m++) begin
        bit act;
        ecc_multi_err = m[0];
        #1;
        act = c[0] && c[1] && !c[2];
        chk(sparing_active == act && ecc_nibble_mode == act, "R2 active", sparing_active, act);
        chk(ecc_uncorr == (m[0] && act) && ecc_fixable == (m[0] && !act), "R3 multi-error",
            {ecc_uncorr, ecc_fixable}, {m[0] && act, m[0] && !act});
      end
    end
    ecc_multi_err = 0;
    @(negedge clk);

    // R9 inactive because of mirror master
    cfg_sparing_en = 1; cfg_all_x4 = 1; cfg_mirror_master = 1;
    cfg_rank_lines = 7'd5;
    send(6, 2);
    wait_idle();
    chk(rd_cnt == 0 && wr_cnt == 0 && remap_valid == '0, "R9 inactive dropped", rd_cnt + wr_cnt, 0);
    // R9 spare index and out-of-range index
    cfg_mirror_master = 0;
    send(6, ND - 1);
    wait_idle();
    send(6, 20);
    wait_idle();
    chk(rd_cnt == 0 && wr_cnt == 0 && remap_valid == '0, "R9 bad index dropped", remap_valid, 0);

    // R5 and R7: migration of rank 0 device 3 over 5 lines
    exp_q.push_back('{0, 3, 5});
    send(0, 3);
    wait_idle();
    chk(prev_remap[0] == 0 && remap_valid[0], "R7 remap with busy fall", remap_valid[0], 1);
    chk(dev_at(0) == 3, "R7 remap device", dev_at(0), 3);
    chk(rd_cnt == 5 && wr_cnt == 5 && exp_q.size() == 0, "R5 line count", wr_cnt, 5);

    // R11 and R4: reports arriving during a migration
    cfg_rank_lines = 7'd3;
    exp_q.push_back('{1, 0, 3});
    exp_q.push_back('{2, 7, 3});
    exp_q.push_back('{3, ND - 2, 3});
    send(1, 0);
    send(2, 7);
    chk(!fail_ready && busy, "R11 held while copying", fail_ready, 0);
    chk(!fail_ready, "R4 ready low when full", fail_ready, 0);
    send(3, ND - 2);
    wait_idle();
    chk(exp_q.size() == 0 && wr_cnt == 14, "R11 all migrations done", wr_cnt, 14);
    chk(remap_valid[3:1] == 3'b111, "R11 remaps set", remap_valid[3:1], 7);
    chk(dev_at(1) == 0 && dev_at(2) == 7 && dev_at(3) == ND - 2, "R7 devices", dev_at(3), ND - 2);

    // R8: zero-length rank
    cfg_rank_lines = '0;
    send(4, 9);
    wait_idle();
    chk(remap_valid[4] && dev_at(4) == 9 && rd_cnt == 14 && wr_cnt == 14, "R8 direct remap",
        dev_at(4), 9);

    // R10: second failures
    cfg_rank_lines = 7'd4;
    rec_cnt = 0;
    send(0, 5);
    wait_idle();
    chk(rec_cnt == 1, "R10 one recovery pulse", rec_cnt, 1);
    chk(second_seen && second_rank == 0 && second_dev == 5, "R10 status", second_dev, 5);
    chk(rd_cnt == 14 && wr_cnt == 14, "R10 no traffic", wr_cnt, 14);
    send(4, 1);
    wait_idle();
    chk(rec_cnt == 2 && second_rank == 4 && second_dev == 1, "R10 status update", second_rank, 4);

    // R12: remaps unchanged by second failures
    chk(dev_at(0) == 3 && dev_at(4) == 9 && remap_valid == 8'h1F, "R12 remap sticky",
        remap_valid, 8'h1F);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule